// File: doc/BRIEF.md
# Address Settle Gate for a 4x4 Memory Decoder

This block sits in front of the row and column decoders of a small memory array. Its address input may move with skewed bit timing or pick up brief glitches. It resynchronises the address and compares every bit with its value one sample earlier. Any difference opens an inhibit window of a fixed number of clock cycles. While the window is open, the decoders are held quiet and no write can reach the array.

Any further bit change during the window starts the count again. An address is captured only when it stays unchanged for the whole window. The row and column one-hot selects are then driven from that captured address. As a result, intermediate codes from bit skew and short noise spikes never select a cell and never produce a write.

After reset, one window runs even if the address does not move. The first stable address is then captured and marked valid.

Top module: `addr_settle_gate`

## Requirements
- R1: While reset is asserted, `busy`, `rowSel`, `colSel`, `wrEn`, `latchedAddr` and `addrValid` are all zero.
- R2: A change of any address bit raises `busy` on the third rising edge after the input changes. Two edges are spent in synchronisation and one in detection.
- R3: For an isolated change, `busy` stays high for exactly HOLD_CYCLES clock cycles.
- R4: A further synchronised change while `busy` is high restarts the count. An intermediate value seen for N ≤ HOLD_CYCLES cycles makes the pulse last HOLD_CYCLES + N cycles.
- R5: Whenever `busy` is high, `rowSel` and `colSel` are all zero and `wrEn` is low.
- R6: An address held for at least HOLD_CYCLES + 1 cycles is captured into `latchedAddr` on the edge where `busy` falls. An address held for HOLD_CYCLES cycles or fewer is never captured.
- R7: When `busy` is low and `addrValid` is high, the selects decode `latchedAddr`. Row index = bits [3:2] and column index = bits [1:0]. `rowSel[i]` is high exactly when the row index equals i, and `colSel` follows the same rule for the column index.
- R8: `wrEn` equals `wrStrobe` when the selects are active (`addrValid` high, `busy` low), and is low otherwise.
- R9: A one-cycle spike on one address bit leaves `latchedAddr` and the active selects the same as before the spike once the window closes.
- R10: After reset is released, one inhibit window runs with no address change. `addrValid` goes high when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | 4 | Raw address; bits [3:2] row, [1:0] column |
| wrStrobe | input | 1 | Write request (1 = write, 0 = read) |
| rowSel | output | 4 | One-hot word-line select |
| colSel | output | 4 | One-hot column select |
| wrEn | output | 1 | Gated write enable to the array |
| latchedAddr | output | 4 | Last address that stayed stable for a full window |
| addrValid | output | 1 | High once the first stable address has been captured |
| busy | output | 1 | Inhibit window active |

## Verification
The bench targets the window boundary. A value held for exactly HOLD_CYCLES cycles must be discarded, and one held a single cycle longer must be captured. A design off by one in its counter would select the short-lived code, or drop the valid one.

Skewed moves through an intermediate code and one-cycle spikes are both driven while a write is requested. A detector that failed to restart would select the intermediate or spike address and raise a write on the wrong cell.

The pulse length is measured against HOLD_CYCLES plus the restart delay. This exposes a design that lets its counter run on instead of restarting it.

The window that follows reset is also checked. A design that waits for an address edge would never assert `addrValid`.

// File: rtl/atd_pkg.sv
package atd_pkg;

  // Strobes passed from the settle controller to the decode datapath.
  typedef struct packed {
    logic latchEn;   // capture the synchronised address this edge
    logic inhibit;   // window open: decoders must stay quiet
  } gateStrobes_t;

endpackage

// File: rtl/atd_settle_ctrl.sv
module atd_settle_ctrl
  import atd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] syncAddr,
  output logic              busy,
  output gateStrobes_t      strobes
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(HOLD_CYCLES - 1);

  logic [ADDR_W-1:0] stage1;
  logic [ADDR_W-1:0] stage2;
  logic [ADDR_W-1:0] prevSample;
  logic [ADDR_W-1:0] bitToggled;
  logic [CNT_W-1:0]  holdCnt;
  logic              busyQ;
  logic              armed;
  logic              anyChange;
  logic              kick;
  logic              expire;

  // One comparator per address bit against its previous sample.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bitCmp
    assign bitToggled[b] = stage2[b] ^ prevSample[b];
  end

  assign anyChange = |bitToggled;
  assign kick      = anyChange | ~armed;
  assign expire    = busyQ & ~kick & (holdCnt == LAST_COUNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1     <= '0;
      stage2     <= '0;
      prevSample <= '0;
      armed      <= 1'b0;
      busyQ      <= 1'b0;
      holdCnt    <= '0;
    end else begin
      stage1     <= addrIn;
      stage2     <= stage1;
      prevSample <= stage2;
      armed      <= 1'b1;
      if (kick) begin
        busyQ   <= 1'b1;
        holdCnt <= '0;
      end else if (busyQ) begin
        if (holdCnt == LAST_COUNT) begin
          busyQ   <= 1'b0;
          holdCnt <= '0;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
    end
  end

  assign syncAddr        = stage2;
  assign busy            = busyQ;
  assign strobes.latchEn = expire;
  assign strobes.inhibit = busyQ;

  // R4: any detected change opens or restarts the window from zero
  p_restart_on_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    anyChange |=> (busyQ && holdCnt == '0));

  // R3: the window only closes after the full count has elapsed
  p_full_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> ($past(holdCnt) == LAST_COUNT));

  // R6: closing the window requires no change in the last cycle
  p_quiet_close_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> !$past(anyChange));

endmodule

// File: rtl/atd_decode_path.sv
module atd_decode_path
  import atd_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ROW_BITS+COL_BITS-1:0] syncAddr,
  input  gateStrobes_t                 strobes,
  input  logic                         wrStrobe,
  output logic [(1<<ROW_BITS)-1:0]     rowSel,
  output logic [(1<<COL_BITS)-1:0]     colSel,
  output logic                         wrEn,
  output logic [ROW_BITS+COL_BITS-1:0] latchedAddr,
  output logic                         addrValid
);

  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int ROWS   = 1 << ROW_BITS;
  localparam int COLS   = 1 << COL_BITS;

  logic [ROW_BITS-1:0] rowIdx;
  logic [COL_BITS-1:0] colIdx;
  logic                selEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedAddr <= '0;
      addrValid   <= 1'b0;
    end else if (strobes.latchEn) begin
      latchedAddr <= syncAddr;
      addrValid   <= 1'b1;
    end
  end

  assign rowIdx    = latchedAddr[ADDR_W-1:COL_BITS];
  assign colIdx    = latchedAddr[COL_BITS-1:0];
  assign selEnable = addrValid & ~strobes.inhibit;

  for (genvar r = 0; r < ROWS; r++) begin : g_rowDec
    assign rowSel[r] = selEnable & (rowIdx == ROW_BITS'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colDec
    assign colSel[c] = selEnable & (colIdx == COL_BITS'(c));
  end

  assign wrEn = selEnable & wrStrobe;

  // R5: an open window silences every select and the write enable
  p_quiet_while_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inhibit |-> (rowSel == '0 && colSel == '0 && !wrEn));

  // R7: outside the window a valid address drives exactly one row and one column
  p_onehot_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.inhibit && addrValid) |-> ($countones(rowSel) == 1 && $countones(colSel) == 1));

  // R6: the captured address moves only on the edge where the window closes
  p_capture_at_close_r6: assert property (@(posedge clk) disable iff (!rstN)
    (latchedAddr != $past(latchedAddr)) |-> ($past(strobes.inhibit) && !strobes.inhibit));

  // R8: no write without an active selection
  p_write_needs_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (rowSel != '0 && colSel != '0 && wrStrobe));

endmodule

// File: rtl/addr_settle_gate.sv
module addr_settle_gate
  import atd_pkg::*;
#(
  parameter int ROW_BITS    = 2,
  parameter int COL_BITS    = 2,
  parameter int HOLD_CYCLES = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ROW_BITS+COL_BITS-1:0] addrIn,
  input  logic                         wrStrobe,
  output logic [(1<<ROW_BITS)-1:0]     rowSel,
  output logic [(1<<COL_BITS)-1:0]     colSel,
  output logic                         wrEn,
  output logic [ROW_BITS+COL_BITS-1:0] latchedAddr,
  output logic                         addrValid,
  output logic                         busy
);

  localparam int ADDR_W = ROW_BITS + COL_BITS;

  logic [ADDR_W-1:0] syncAddr;
  gateStrobes_t      strobes;

  atd_settle_ctrl #(
    .ADDR_W      (ADDR_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (addrIn),
    .syncAddr (syncAddr),
    .busy     (busy),
    .strobes  (strobes)
  );

  atd_decode_path #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .syncAddr    (syncAddr),
    .strobes     (strobes),
    .wrStrobe    (wrStrobe),
    .rowSel      (rowSel),
    .colSel      (colSel),
    .wrEn        (wrEn),
    .latchedAddr (latchedAddr),
    .addrValid   (addrValid)
  );

endmodule

// File: tb/addr_settle_gate_test.sv
`timescale 1ns/1ps
module addr_settle_gate_test;

  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] addrIn;
  logic       wrStrobe;
  logic [3:0] rowSel;
  logic [3:0] colSel;
  logic       wrEn;
  logic [3:0] latchedAddr;
  logic       addrValid;
  logic       busy;

  always #5 clk = ~clk;

  addr_settle_gate #(.ROW_BITS(2), .COL_BITS(2), .HOLD_CYCLES(H)) uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .wrStrobe(wrStrobe),
    .rowSel(rowSel), .colSel(colSel), .wrEn(wrEn),
    .latchedAddr(latchedAddr), .addrValid(addrValid), .busy(busy)
  );

  typedef struct {
    logic [3:0] addr;
    int         len;
  } expItem_t;

  expItem_t expQ[$];
  int  compared   = 0;
  int  mismatched = 0;
  bit  finished   = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_window(logic [3:0] a, int len);
    expItem_t it;
    it.addr = a;
    it.len  = len;
    expQ.push_back(it);
  endtask

  task automatic hold(logic [3:0] a, int n);
    addrIn = a;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: scoreboard side, sampled at the falling edge.
  logic [3:0] curAddr  = 4'h0;
  bit         prevBusy = 1'b0;
  int         runLen   = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        runLen++;
        check("R5", 32'({rowSel, colSel, wrEn}), 32'h0);
      end else begin
        if (prevBusy) begin
          if (expQ.size() == 0) begin
            check("R6", 32'(latchedAddr), 32'hDEAD);
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            check("R6", 32'(latchedAddr), 32'(it.addr));
            check((it.len == H) ? "R3" : "R4", 32'(runLen), 32'(it.len));
            curAddr = it.addr;
          end
          runLen = 0;
        end
        if (addrValid) begin
          check("R7", 32'(rowSel), 32'(4'b0001 << curAddr[3:2]));
          check("R7", 32'(colSel), 32'(4'b0001 << curAddr[1:0]));
          check("R8", 32'(wrEn), 32'(wrStrobe));
        end else begin
          check("R8", 32'(wrEn), 32'h0);
        end
      end
      prevBusy = busy;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Driver
  initial begin
    rstN     = 1'b0;
    addrIn   = 4'h0;
    wrStrobe = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'(busy), 32'h0);
    check("R1", 32'({rowSel, colSel}), 32'h0);
    check("R1", 32'(wrEn), 32'h0);
    check("R1", 32'(latchedAddr), 32'h0);
    check("R1", 32'(addrValid), 32'h0);

    // R10: a window runs after reset with no address change
    expect_window(4'h0, H);
    rstN = 1'b1;
    repeat (H + 4) @(negedge clk);
    check("R10", 32'(addrValid), 32'h1);
    check("R10", 32'(latchedAddr), 32'h0);

    // R2: detection latency on a clean change, then R3 length
    expect_window(4'h6, H);
    addrIn = 4'h6;
    repeat (2) @(negedge clk);
    check("R2", 32'(busy), 32'h0);
    @(negedge clk);
    check("R2", 32'(busy), 32'h1);
    repeat (H + 8) @(negedge clk);

    // R8: write request while stable
    wrStrobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", 32'(wrEn), 32'h1);

    // R9: one-cycle spike on bit 0 with a write pending
    expect_window(4'h6, H + 1);
    hold(4'h7, 1);
    hold(4'h6, H + 8);
    check("R9", 32'(latchedAddr), 32'h6);
    check("R9", 32'({rowSel, colSel}), 32'({4'b0010, 4'b0100}));

    // R4: skewed move 6 -> 9 passing through E for three cycles
    expect_window(4'h9, H + 3);
    hold(4'hE, 3);
    hold(4'h9, H + 8);

    // R6: value held exactly H cycles is discarded
    expect_window(4'h3, 2 * H);
    hold(4'hF, H);
    hold(4'h3, H + 8);
    check("R6", 32'(latchedAddr), 32'h3);

    // R6: value held H+1 cycles is captured
    wrStrobe = 1'b0;
    expect_window(4'hC, H);
    expect_window(4'h5, H);
    hold(4'hC, H + 1);
    hold(4'h5, H + 8);
    check("R6", 32'(latchedAddr), 32'h5);
    check("R8", 32'(wrEn), 32'h0);

    repeat (4) @(negedge clk);
    check("R6", 32'(expQ.size()), 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule